// File: doc/BRIEF.md
# Associative Address Translation Buffer with Access Protection

This block turns a 32-bit virtual address into a 29-bit physical address by searching two fully associative tables of page entries. A small fetch table is used only for instruction fetches. A larger shared table serves both data accesses and any fetch that misses the small table. Each entry carries its own page size, an address-space tag, a shared flag, a two-bit protection field and a dirty flag. After a hit, the block checks the access against the privilege level, the access direction and the dirty flag. It then reports one of three outcomes: a read-only grant, a read-write grant, or an exception code.

The lookup is purely combinational and needs no handshake. The caller presents the address and access attributes and reads the result in the same cycle. Entries are loaded through a synchronous write port and can be looked up from the next cycle on. A probe flag lets software ask about an address without raising an exception. Detecting several matching entries at once is not part of the block.

Top module: `tlb_lookup_unit`

## Requirements
- R1: A synchronous active-low reset invalidates every entry in both tables, so every lookup in the first cycle after reset misses.
- R2: An entry matches only when its valid flag is set and the virtual address agrees with the entry tag on the page-number bits its size keeps. The size codes are 0 = 1 KB (bits 31:10), 1 = 4 KB (bits 31:12), 2 = 64 KB (bits 31:16) and 3 = 1 MB (bits 31:20).
- R3: When the single-virtual mode input is low, or the access is unprivileged, a non-shared entry also needs its address-space tag to equal the current one. Shared entries, and privileged accesses in single-virtual mode, skip this comparison.
- R4: On a grant, the physical address takes the virtual bits below the page boundary and the entry frame bits above it, truncated to 29 bits.
- R5: When several shared-table entries match, the one with the lowest index is used.
- R6: A fetch searches the fetch table first and falls back to the shared table. Data accesses never use the fetch table. A fetch is always treated as a read.
- R7: A privileged fetch is granted for any protection value. An unprivileged fetch needs protection bit 1 set, otherwise it is a load protection fault. Fetch grants are always read-only (grant code 1).
- R8: For privileged data, protection values 0 and 2 give read-only access, so a write to them is a store protection fault. Values 1 and 3 permit writes.
- R9: For unprivileged data, protection values 0 and 1 always fault, value 2 is read-only (a write faults), and value 3 permits writes.
- R10: For a permitted write, a clean entry raises the first-write code 0x105 and a dirty entry is granted read-write. A granted data read reports read-write (2) when the entry is dirty and read-only (1) otherwise.
- R11: A miss raises 0x101 for a load or fetch and 0x102 for a store. A protection fault raises 0x103 for a load or fetch and 0x104 for a store. Whenever an exception is raised, the grant is 0, the physical address is 0 and `hit` still reports whether an entry matched.
- R12: With the probe flag set, any failure is reported as a read-write grant with physical address 0, no exception and code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load one entry this cycle |
| wr_itlb | input | 1 | 1 = fetch table, 0 = shared table |
| wr_idx | input | IDX_W | Entry slot; slots beyond the chosen table are ignored |
| wr_vpn | input | 22 | Virtual page tag, address bits 31:10 |
| wr_asid | input | 8 | Address-space tag of the entry |
| wr_pfn | input | 19 | Physical frame, address bits 28:10 |
| wr_size | input | 2 | Page size code |
| wr_valid | input | 1 | Entry valid flag |
| wr_shared | input | 1 | Entry shared flag |
| wr_dirty | input | 1 | Entry dirty flag |
| wr_prot | input | 2 | Protection field |
| lk_va | input | 32 | Virtual address |
| lk_write | input | 1 | 1 = store |
| lk_fetch | input | 1 | 1 = instruction fetch |
| lk_priv | input | 1 | 1 = privileged mode |
| lk_asid | input | 8 | Current address-space tag |
| lk_single_vm | input | 1 | Single-virtual mode |
| lk_probe | input | 1 | Probe without exception |
| hit | output | 1 | An entry matched |
| grant | output | 2 | 0 none, 1 read-only, 2 read-write |
| paddr | output | 29 | Physical address |
| exc_valid | output | 1 | An exception is raised |
| exc_code | output | 12 | Exception code |

## Verification
A sweep covers every combination of direction, fetch, privilege, tag match, single-virtual mode and probe. It runs over pages that cover all four protection values, both dirty states, each size, a shared entry, an invalid entry and an unmapped address. This separates the protection matrix and the fault encodings for privileged and unprivileged access. Directed lookups at the first and last byte of each page, and one byte past it, show whether the size mask keeps the right bits. A duplicated page separates lowest-index priority from any other choice. A page present in both tables, looked up once as a fetch and once as data, shows which table each access type searches.

// File: rtl/tlb_pkg.sv
// Shared widths, entry layout, outcome type and exception codes for the
// translation buffer. Assumes 32-bit virtual and 29-bit physical addresses.
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 29;
    localparam int PG_LSB = 10;
    localparam int VPN_W  = VA_W - PG_LSB;
    localparam int PFN_W  = PA_W - PG_LSB;
    localparam int ASID_W = 8;
    localparam int EXC_W  = 12;

    typedef enum logic [1:0] {PG_1K = 2'd0, PG_4K = 2'd1, PG_64K = 2'd2, PG_1M = 2'd3} pg_size_e;
    typedef enum logic [1:0] {PM_RO, PM_RW, PM_VIOL, PM_FIRSTWR} perm_e;

    localparam logic [1:0] GRANT_NONE = 2'd0;
    localparam logic [1:0] GRANT_RO   = 2'd1;
    localparam logic [1:0] GRANT_RW   = 2'd2;

    localparam logic [EXC_W-1:0] EXC_NONE     = 12'h000;
    localparam logic [EXC_W-1:0] EXC_MISS_LD  = 12'h101;
    localparam logic [EXC_W-1:0] EXC_MISS_ST  = 12'h102;
    localparam logic [EXC_W-1:0] EXC_PROT_LD  = 12'h103;
    localparam logic [EXC_W-1:0] EXC_PROT_ST  = 12'h104;
    localparam logic [EXC_W-1:0] EXC_FIRST_WR = 12'h105;

    typedef struct packed {
        logic              valid;
        logic              shared;
        logic              dirty;
        logic [1:0]        prot;
        pg_size_e          size;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
    } tlb_entry_t;

    // Page-number bits (31:10) that take part in the compare for a size.
    function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e s);
        case (s)
            PG_1K:   vpn_mask = {VPN_W{1'b1}};
            PG_4K:   vpn_mask = {{(VPN_W-2){1'b1}}, 2'b0};
            PG_64K:  vpn_mask = {{(VPN_W-6){1'b1}}, 6'b0};
            default: vpn_mask = {{(VPN_W-10){1'b1}}, 10'b0};
        endcase
    endfunction
endpackage

// File: rtl/tlb_pick.sv
// Priority picker: reports whether any request is set and the index of the
// lowest set one. Assumes N >= 1.
module tlb_pick #(
    parameter int N = 4,
    localparam int LW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [LW-1:0] idx
);
    // Scan from the top so the lowest set request is assigned last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = LW'(i);
        end
    end

    // Any request present.
    assign found = |req;
endmodule

// File: rtl/tlb_table.sv
// One associative table: entry storage with a write port, per-entry compare
// on size-masked page number and conditional address-space tag, and
// lowest-index selection. Only the valid flags are cleared by reset.
module tlb_table
    import tlb_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 4,
    localparam int LW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_entry_t        wr_entry,
    input  logic [VPN_W-1:0]  va_vpn,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              need_asid,
    output logic              found,
    output tlb_entry_t        sel_entry
);
    tlb_entry_t      ents [N];
    logic [N-1:0]    match;
    logic [LW-1:0]   sel_idx;
    logic [LW-1:0]   widx;

    assign widx = wr_idx[LW-1:0];

    // Reset clears the valid flags; a write stores one in-range entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ents[i].valid <= 1'b0;
        end else if (wr_en && (int'(wr_idx) < N)) begin
            ents[widx] <= wr_entry;
        end
    end

    // One comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic tag_ok;
        logic id_ok;
        assign tag_ok   = ((ents[g].vpn ^ va_vpn) & vpn_mask(ents[g].size)) == '0;
        assign id_ok    = ents[g].shared || !need_asid || (ents[g].asid == cur_asid);
        assign match[g] = ents[g].valid && tag_ok && id_ok;
    end

    tlb_pick #(.N(N)) u_pick (
        .req   (match),
        .found (found),
        .idx   (sel_idx)
    );

    // Selected entry contents.
    assign sel_entry = ents[sel_idx];
endmodule

// File: rtl/tlb_perm.sv
// Protection check: maps protection field, dirty flag, privilege, fetch and
// direction to read-only, read-write, violation or first-write outcome.
// Assumes the caller has already cleared the write flag for fetches.
module tlb_perm
    import tlb_pkg::*;
(
    input  logic [1:0] prot,
    input  logic       dirty,
    input  logic       priv,
    input  logic       fetch,
    input  logic       wr,
    output perm_e      perm
);
    logic wr_allowed;
    logic rd_allowed;

    // Which accesses the protection field permits at this privilege.
    always_comb begin
        if (priv) begin
            rd_allowed = 1'b1;
            wr_allowed = prot[0];
        end else begin
            rd_allowed = prot[1];
            wr_allowed = (prot == 2'd3);
        end
    end

    // Final outcome for the access.
    always_comb begin
        if (fetch)            perm = (priv || prot[1]) ? PM_RO : PM_VIOL;
        else if (!rd_allowed) perm = PM_VIOL;
        else if (wr && !wr_allowed) perm = PM_VIOL;
        else if (wr && !dirty)      perm = PM_FIRSTWR;
        else if (wr_allowed && dirty) perm = PM_RW;
        else                  perm = PM_RO;
    end
endmodule

// File: rtl/tlb_lookup_unit.sv
// Translation buffer top: fetch table searched before the shared table for
// fetches, protection check, physical address assembly and exception or
// probe reporting. Lookup is combinational; loads take effect next cycle.
module tlb_lookup_unit
    import tlb_pkg::*;
#(
    parameter int ITLB_N = 4,
    parameter int UTLB_N = 16,
    localparam int MAX_N = (UTLB_N > ITLB_N) ? UTLB_N : ITLB_N,
    localparam int IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_itlb,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [1:0]        wr_size,
    input  logic              wr_valid,
    input  logic              wr_shared,
    input  logic              wr_dirty,
    input  logic [1:0]        wr_prot,
    input  logic [VA_W-1:0]   lk_va,
    input  logic              lk_write,
    input  logic              lk_fetch,
    input  logic              lk_priv,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_single_vm,
    input  logic              lk_probe,
    output logic              hit,
    output logic [1:0]        grant,
    output logic [PA_W-1:0]   paddr,
    output logic              exc_valid,
    output logic [EXC_W-1:0]  exc_code
);
    tlb_entry_t       wr_entry;
    tlb_entry_t       i_sel, u_sel, sel;
    logic             i_found, u_found, use_i, found;
    logic             need_asid, eff_wr;
    perm_e            perm;
    logic [PFN_W-1:0] fmask;
    logic [PA_W-1:0]  xlat_pa;

    // Pack the write-port fields into one entry.
    always_comb begin
        wr_entry.valid  = wr_valid;
        wr_entry.shared = wr_shared;
        wr_entry.dirty  = wr_dirty;
        wr_entry.prot   = wr_prot;
        wr_entry.size   = pg_size_e'(wr_size);
        wr_entry.vpn    = wr_vpn;
        wr_entry.asid   = wr_asid;
        wr_entry.pfn    = wr_pfn;
    end

    assign need_asid = !lk_single_vm || !lk_priv;
    assign eff_wr    = lk_write && !lk_fetch;

    tlb_table #(.N(ITLB_N), .IDX_W(IDX_W)) u_itab (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && wr_itlb), .wr_idx(wr_idx),
        .wr_entry(wr_entry), .va_vpn(lk_va[VA_W-1:PG_LSB]), .cur_asid(lk_asid),
        .need_asid(need_asid), .found(i_found), .sel_entry(i_sel)
    );

    tlb_table #(.N(UTLB_N), .IDX_W(IDX_W)) u_utab (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && !wr_itlb), .wr_idx(wr_idx),
        .wr_entry(wr_entry), .va_vpn(lk_va[VA_W-1:PG_LSB]), .cur_asid(lk_asid),
        .need_asid(need_asid), .found(u_found), .sel_entry(u_sel)
    );

    // Fetches prefer the fetch table; data uses the shared table only.
    assign use_i = lk_fetch && i_found;
    assign found = use_i || u_found;
    assign sel   = use_i ? i_sel : u_sel;

    tlb_perm u_perm (
        .prot(sel.prot), .dirty(sel.dirty), .priv(lk_priv),
        .fetch(lk_fetch), .wr(eff_wr), .perm(perm)
    );

    // Offset from the virtual address, frame bits from the entry.
    assign fmask   = vpn_mask(sel.size)[PFN_W-1:0];
    assign xlat_pa = {(lk_va[PA_W-1:PG_LSB] & ~fmask) | (sel.pfn & fmask), lk_va[PG_LSB-1:0]};

    // Resolve the outcome into grant, address and exception outputs.
    always_comb begin
        logic             fail;
        logic [EXC_W-1:0] code;
        fail  = 1'b0;
        code  = EXC_NONE;
        grant = GRANT_NONE;
        paddr = '0;
        if (!found) begin
            fail = 1'b1;
            code = eff_wr ? EXC_MISS_ST : EXC_MISS_LD;
        end else begin
            case (perm)
                PM_RO:      begin grant = GRANT_RO; paddr = xlat_pa; end
                PM_RW:      begin grant = GRANT_RW; paddr = xlat_pa; end
                PM_VIOL:    begin fail = 1'b1; code = eff_wr ? EXC_PROT_ST : EXC_PROT_LD; end
                default:    begin fail = 1'b1; code = EXC_FIRST_WR; end
            endcase
        end
        if (fail && lk_probe) begin
            grant     = GRANT_RW;
            exc_valid = 1'b0;
            exc_code  = EXC_NONE;
        end else begin
            exc_valid = fail;
            exc_code  = code;
        end
        hit = found;
    end
endmodule

// File: rtl/tlb_lookup_chk.sv
// Property checker for the translation buffer, attached by bind. Relates
// the lookup inputs to the reported grant and exception outputs.
module tlb_lookup_chk
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_write,
    input logic             lk_fetch,
    input logic             lk_probe,
    input logic             hit,
    input logic [1:0]       grant,
    input logic [PA_W-1:0]  paddr,
    input logic             exc_valid,
    input logic [EXC_W-1:0] exc_code
);
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !hit);

    p_fetch_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fetch && !lk_probe) |-> (grant != GRANT_RW));

    p_granted_write_rw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_write && !lk_fetch && !lk_probe && !exc_valid) |-> (grant == GRANT_RW));

    p_miss_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !lk_probe) |-> (exc_valid && (exc_code == EXC_MISS_LD || exc_code == EXC_MISS_ST)));

    p_exc_clears_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (grant == GRANT_NONE && paddr == '0 && exc_code != EXC_NONE));

    p_probe_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lk_probe |-> (!exc_valid && exc_code == EXC_NONE && grant != GRANT_NONE));
endmodule

bind tlb_lookup_unit tlb_lookup_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lk_write(lk_write), .lk_fetch(lk_fetch),
    .lk_probe(lk_probe), .hit(hit), .grant(grant), .paddr(paddr),
    .exc_valid(exc_valid), .exc_code(exc_code)
);

// File: tb/tlb_lookup_unit_tb_top.sv
`timescale 1ns/1ps
module tlb_lookup_unit_tb_top;
    localparam int IN = 4;
    localparam int UN = 16;
    localparam int IW = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, wr_itlb = 0;
    logic [IW-1:0] wr_idx = '0;
    logic [21:0] wr_vpn = '0;
    logic [7:0]  wr_asid = '0;
    logic [18:0] wr_pfn = '0;
    logic [1:0]  wr_size = '0, wr_prot = '0;
    logic        wr_valid = 0, wr_shared = 0, wr_dirty = 0;
    logic [31:0] lk_va = '0;
    logic        lk_write = 0, lk_fetch = 0, lk_priv = 0, lk_single_vm = 0, lk_probe = 0;
    logic [7:0]  lk_asid = '0;
    logic        hit, exc_valid;
    logic [1:0]  grant;
    logic [28:0] paddr;
    logic [11:0] exc_code;

    int    checks = 0, failures = 0;
    bit    chk_on = 0, done = 0, auto_tag = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    tlb_lookup_unit #(.ITLB_N(IN), .UTLB_N(UN)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_itlb(wr_itlb), .wr_idx(wr_idx),
        .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_pfn(wr_pfn), .wr_size(wr_size),
        .wr_valid(wr_valid), .wr_shared(wr_shared), .wr_dirty(wr_dirty), .wr_prot(wr_prot),
        .lk_va(lk_va), .lk_write(lk_write), .lk_fetch(lk_fetch), .lk_priv(lk_priv),
        .lk_asid(lk_asid), .lk_single_vm(lk_single_vm), .lk_probe(lk_probe),
        .hit(hit), .grant(grant), .paddr(paddr), .exc_valid(exc_valid), .exc_code(exc_code)
    );

    // Behavioural model tables
    bit          mi_v[IN], mi_sh[IN], mi_d[IN];
    logic [31:0] mi_va[IN];
    logic [28:0] mi_pa[IN];
    int          mi_as[IN], mi_sz[IN], mi_pr[IN];
    bit          mu_v[UN], mu_sh[UN], mu_d[UN];
    logic [31:0] mu_va[UN];
    logic [28:0] mu_pa[UN];
    int          mu_as[UN], mu_sz[UN], mu_pr[UN];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < IN; i++) mi_v[i] = 0;
            for (int i = 0; i < UN; i++) mu_v[i] = 0;
        end else if (wr_en) begin
            if (wr_itlb && int'(wr_idx) < IN) begin
                mi_v[wr_idx] = wr_valid; mi_sh[wr_idx] = wr_shared; mi_d[wr_idx] = wr_dirty;
                mi_va[wr_idx] = {wr_vpn, 10'b0}; mi_pa[wr_idx] = {wr_pfn, 10'b0};
                mi_as[wr_idx] = int'(wr_asid); mi_sz[wr_idx] = int'(wr_size); mi_pr[wr_idx] = int'(wr_prot);
            end else if (!wr_itlb && int'(wr_idx) < UN) begin
                mu_v[wr_idx] = wr_valid; mu_sh[wr_idx] = wr_shared; mu_d[wr_idx] = wr_dirty;
                mu_va[wr_idx] = {wr_vpn, 10'b0}; mu_pa[wr_idx] = {wr_pfn, 10'b0};
                mu_as[wr_idx] = int'(wr_asid); mu_sz[wr_idx] = int'(wr_size); mu_pr[wr_idx] = int'(wr_prot);
            end
        end
    end

    function automatic logic [31:0] page_mask(int s);
        case (s)
            0: return 32'hFFFF_FC00;
            1: return 32'hFFFF_F000;
            2: return 32'hFFFF_0000;
            default: return 32'hFFF0_0000;
        endcase
    endfunction

    // kind: 0 RO, 1 RW, 2 protection fault, 3 first write, 4 miss
    task automatic ref_eval(output bit e_hit, output logic [1:0] e_gr, output logic [28:0] e_pa,
                            output bit e_ex, output logic [11:0] e_code, output int kind);
        bit need = !lk_single_vm || !lk_priv;
        bit w = lk_write && !lk_fetch;
        bit fnd = 0;
        int pr = 0, sz = 0;
        bit d = 0;
        logic [28:0] pa = '0;
        logic [31:0] m, full;
        if (lk_fetch)
            for (int i = 0; i < IN; i++)
                if (!fnd && mi_v[i] && ((mi_va[i] ^ lk_va) & page_mask(mi_sz[i])) == 0
                    && (mi_sh[i] || !need || mi_as[i] == int'(lk_asid))) begin
                    fnd = 1; pr = mi_pr[i]; d = mi_d[i]; pa = mi_pa[i]; sz = mi_sz[i];
                end
        if (!fnd)
            for (int i = 0; i < UN; i++)
                if (!fnd && mu_v[i] && ((mu_va[i] ^ lk_va) & page_mask(mu_sz[i])) == 0
                    && (mu_sh[i] || !need || mu_as[i] == int'(lk_asid))) begin
                    fnd = 1; pr = mu_pr[i]; d = mu_d[i]; pa = mu_pa[i]; sz = mu_sz[i];
                end
        if (!fnd) kind = 4;
        else if (lk_fetch) kind = (lk_priv || pr >= 2) ? 0 : 2;
        else if (!lk_priv && pr < 2) kind = 2;
        else if ((pr == 0 || pr == 2) && w) kind = 2;
        else if (pr == 0 || pr == 2) kind = 0;
        else if (w && !d) kind = 3;
        else kind = d ? 1 : 0;
        m = page_mask(sz);
        full = (lk_va & ~m) | ({3'b0, pa} & m);
        e_hit = fnd; e_ex = 0; e_code = 12'h000; e_gr = 2'd0; e_pa = '0;
        if (kind <= 1) begin
            e_gr = (kind == 1) ? 2'd2 : 2'd1; e_pa = full[28:0];
        end else if (lk_probe) begin
            e_gr = 2'd2;
        end else begin
            e_ex = 1;
            if (kind == 4) e_code = w ? 12'h102 : 12'h101;
            else if (kind == 2) e_code = w ? 12'h104 : 12'h103;
            else e_code = 12'h105;
        end
    endtask

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            bit e_hit, e_ex;
            logic [1:0] e_gr;
            logic [28:0] e_pa;
            logic [11:0] e_code;
            int kind;
            string t;
            ref_eval(e_hit, e_gr, e_pa, e_ex, e_code, kind);
            t = tag;
            if (auto_tag) begin
                if (lk_probe && kind >= 2) t = "R12";
                else if (kind == 4) t = "R11";
                else if (lk_fetch) t = "R7";
                else if (kind == 3 || kind == 1) t = "R10";
                else if (lk_priv) t = "R8";
                else t = "R9";
            end
            checks++;
            if (hit !== e_hit || grant !== e_gr || paddr !== e_pa || exc_valid !== e_ex || exc_code !== e_code) begin
                failures++;
                $display("FAIL %s va=%h actual hit=%0d grant=%0d paddr=%h exc=%0d code=%h expected hit=%0d grant=%0d paddr=%h exc=%0d code=%h",
                         t, lk_va, hit, grant, paddr, exc_valid, exc_code, e_hit, e_gr, e_pa, e_ex, e_code);
            end
        end
    end

    task automatic load(bit itl, int idx, logic [31:0] va, int as, logic [28:0] pa, int sz,
                        bit v, bit sh, bit d, int pr);
        wr_en = 1; wr_itlb = itl; wr_idx = IW'(idx); wr_vpn = va[31:10]; wr_asid = 8'(as);
        wr_pfn = pa[28:10]; wr_size = 2'(sz); wr_valid = v; wr_shared = sh; wr_dirty = d; wr_prot = 2'(pr);
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic look(logic [31:0] va, bit w, bit f, bit p, int as, bit sv, bit pb);
        lk_va = va; lk_write = w; lk_fetch = f; lk_priv = p; lk_asid = 8'(as);
        lk_single_vm = sv; lk_probe = pb;
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    logic [31:0] pages [9] = '{32'h1000_0123, 32'h1001_03FF, 32'h1020_FFFC, 32'h200F_FFF0,
                               32'h3000_0800, 32'h4000_0010, 32'h5000_0000, 32'h6000_0444,
                               32'h8000_0000};

    initial begin
        // R1: reset state, lookups miss
        @(posedge clk); #1;
        chk_on = 1;
        tag = "R1";
        repeat (3) look(32'h1000_0000, 0, 0, 1, 5, 0, 0);
        rst_n = 1;
        look(32'h1000_0000, 0, 0, 1, 5, 0, 0);

        tag = "R2";
        load(0, 0, 32'h1000_0000, 5, 29'h0123_4000, 1, 1, 0, 1, 3);
        load(0, 1, 32'h1001_0000, 5, 29'h0023_0400, 0, 1, 0, 0, 3);
        load(0, 2, 32'h1020_0000, 5, 29'h0AB0_0000, 2, 1, 0, 1, 1);
        load(0, 3, 32'h2000_0000, 5, 29'h1F00_0000, 3, 1, 1, 1, 2);
        load(0, 4, 32'h3000_0000, 5, 29'h0000_5000, 1, 1, 0, 1, 0);
        load(0, 5, 32'h1000_0000, 5, 29'h0777_7000, 1, 1, 0, 1, 3);
        load(0, 6, 32'h4000_0000, 9, 29'h0444_4000, 1, 1, 0, 0, 1);
        load(0, 7, 32'h5000_0000, 5, 29'h0555_5000, 1, 0, 0, 1, 3);
        load(1, 0, 32'h1000_0000, 5, 29'h0999_9000, 1, 1, 0, 0, 2);
        load(1, 1, 32'h6000_0000, 5, 29'h0111_1000, 1, 1, 0, 0, 0);

        // R2: page boundaries for each size
        look(32'h1000_0FFF, 0, 0, 1, 5, 0, 0);
        look(32'h1000_1000, 0, 0, 1, 5, 0, 0);
        look(32'h1001_03FF, 0, 0, 1, 5, 0, 0);
        look(32'h1001_0400, 0, 0, 1, 5, 0, 0);
        look(32'h1020_FFFF, 0, 0, 1, 5, 0, 0);
        look(32'h1021_0000, 0, 0, 1, 5, 0, 0);
        look(32'h200F_FFFF, 0, 0, 1, 5, 0, 0);
        look(32'h2010_0000, 0, 0, 1, 5, 0, 0);
        look(32'h5000_0000, 0, 0, 1, 5, 0, 0);
        // R3: address-space tag rules
        tag = "R3";
        look(32'h1000_0000, 0, 0, 1, 6, 0, 0);
        look(32'h1000_0000, 0, 0, 1, 6, 1, 0);
        look(32'h1000_0000, 0, 0, 0, 6, 1, 0);
        look(32'h2000_0000, 0, 0, 0, 6, 0, 0);
        // R4: address assembly
        tag = "R4";
        look(32'h200A_BCDE, 0, 0, 1, 5, 0, 0);
        look(32'hF020_1234, 0, 0, 1, 5, 0, 0);
        // R5: duplicate page, lowest index wins
        tag = "R5";
        look(32'h1000_0ABC, 0, 0, 1, 5, 0, 0);
        // R6: fetch table first for fetches only
        tag = "R6";
        look(32'h1000_0010, 0, 1, 1, 5, 0, 0);
        look(32'h1000_0010, 0, 0, 1, 5, 0, 0);
        look(32'h1000_0010, 1, 1, 0, 5, 0, 0);
        look(32'h6000_0000, 0, 0, 1, 5, 0, 0);
        // R10: dirty versus clean
        tag = "R10";
        look(32'h1000_0004, 1, 0, 1, 5, 0, 0);
        look(32'h1001_0004, 0, 0, 1, 5, 0, 0);
        look(32'h1001_0004, 1, 0, 0, 5, 0, 0);

        // Sweep: R7, R8, R9, R10, R11, R12 tagged per outcome
        auto_tag = 1;
        for (int p = 0; p < 9; p++)
            for (int c = 0; c < 64; c++)
                look(pages[p], c[0], c[1], c[2], c[3] ? 5 : 6, c[4], c[5]);
        auto_tag = 0;

        // R1: reset again clears everything
        tag = "R1";
        rst_n = 0;
        look(32'h1000_0000, 0, 0, 1, 5, 0, 0);
        rst_n = 1;
        look(32'h1000_0000, 0, 0, 1, 5, 0, 0);
        look(32'h1000_0000, 0, 1, 1, 5, 0, 0);
        finish_run();
    end
endmodule